// File: doc/BRIEF.md
# SPI Register-Access Transaction Master

This block is an SPI master that performs one register write or one register read on an SPI-attached Ethernet MAC-PHY per request. Each request carries a write/read flag, a 4-bit memory-map select, a 16-bit register address and 32-bit write data. The block assembles a 32-bit control header from these fields and adds a parity bit. It then runs the whole transaction while holding chip select low, and returns a one-cycle done pulse. A read also returns a data word and an error flag.

A write sends the header and then the data word, and ignores everything received on MISO. A read sends the header followed by all-zero filler words. The number of filler words is the `ECHO_IDX` parameter, and the reply is the received word at position `ECHO_IDX`, counting from 0. When `ECHO_IDX` is 2 or more, received word 1 is expected to be an echo of the header, and any mismatch is reported on the error flag. Parameters set the SCK period, the chip-select lead and hold times and the gap between words, all counted in cycles of `clk_i`.

Top module: `spi_reg_master`

## Requirements
- R1: While `rst_ni` is low, and after it is released, the outputs are `spi_cs_no`=1, `spi_sck_o`=0, `spi_mosi_o`=0, `req_ready_o`=1 and `done_o`=0.
- R2: A request is taken only in a cycle where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` stays low from acceptance until the done cycle. Requests offered while the block is busy are ignored and do not alter the running transaction.
- R3: The header word is built as follows: bit 31 = 0 (control), bit 30 = 0, bit 29 = write flag (1 = write), bit 28 = 0, bits 27:24 = memory-map select, bits 23:8 = register address, bits 7:1 = 0 (one register).
- R4: Header bit 0 is chosen so that the full 32-bit header holds an odd number of ones.
- R5: Every frame is 32 bits long and sent MSB first. SCK idles low. MOSI changes only while SCK is low, and MISO is sampled on the rising SCK edge.
- R6: A write sends exactly two frames, the header and then the write data, within a single chip-select low period. `rdata_o` does not change.
- R7: A read sends the header followed by `ECHO_IDX` all-zero frames within a single chip-select low period. `rdata_o` then shows received frame number `ECHO_IDX` (0-based).
- R8: When `ECHO_IDX` ≥ 2, `err_o` is high in the done cycle of a read exactly when received frame 1 differs from the sent header. `err_o` is low after writes and whenever `ECHO_IDX` = 1.
- R9: Timing in `clk_i` cycles. SCK rises every `CLK_DIV` cycles inside a frame. The first rising edge comes `CS_LEAD` cycles after chip select falls. From the last falling edge of a frame to the first rising edge of the next frame is `WORD_GAP` cycles. From the last falling edge to chip-select release is `CS_HOLD` cycles.
- R10: `done_o` is high for exactly one cycle, the first cycle with chip select released. `rdata_o` changes only in a done cycle of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_mms_i | input | 4 | Memory-map select |
| req_addr_i | input | 16 | Register address |
| req_wdata_i | input | 32 | Write data |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Header echo mismatch, valid with done |
| rdata_o | output | 32 | Read data, held until the next read completes |
| spi_cs_no | output | 1 | Chip select, active low |
| spi_sck_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data out |
| spi_miso_i | input | 1 | Serial data in |

## Verification
The bench sweeps all 16 memory-map selects and every single-bit address. It checks each captured header against an independently computed word, so a misplaced field or inverted parity shows up as a header miscompare. Two instances run side by side, one with `ECHO_IDX` 2 and one with 1, each with a slave model that puts distinct filler values in every reply frame. A design that returns the wrong word, or sends the wrong number of frames, therefore produces a wrong value or a wrong frame count. Further tests cover a corrupted header echo, requests offered while a transaction is running, an asynchronous reset in the middle of a frame, and the lead, gap, hold and period measurements taken at the pins. An off-by-one cycle in any counter shows up as a timing miscompare.

// File: rtl/spi_txn_pkg.sv
package spi_txn_pkg;

  localparam int unsigned FRAME_W = 32;
  localparam int unsigned MMS_W   = 4;
  localparam int unsigned ADDR_W  = 16;
  localparam int unsigned LEN_W   = 7;

  typedef struct packed {
    logic              wr;
    logic [MMS_W-1:0]  mms;
    logic [ADDR_W-1:0] addr;
    logic [FRAME_W-1:0] wdata;
  } txn_req_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_GAP,
    ST_HOLD
  } seq_state_e;

  // bit that makes the whole word odd
  function automatic logic odd_fill(input logic [FRAME_W-2:0] upper);
    return ~(^upper);
  endfunction

endpackage

// File: rtl/spi_hdr_build.sv
module spi_hdr_build
  import spi_txn_pkg::*;
(
  input  logic              wr_i,
  input  logic [MMS_W-1:0]  mms_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [FRAME_W-1:0] hdr_o
);

  localparam logic [LEN_W-1:0] LEN_ONE_REG = '0; // count minus one

  logic [FRAME_W-2:0] upper;

  always_comb begin
    upper = {1'b0,            // control frame
             1'b0,            // header-bad, driven low
             wr_i,
             1'b0,            // auto-increment kept on
             mms_i,
             addr_i,
             LEN_ONE_REG};
    hdr_o = {upper, odd_fill(upper)};
  end

endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
  parameter int unsigned FRAME_W  = 32,
  parameter int unsigned HALF_DIV = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               go_i,
  input  logic [FRAME_W-1:0] tx_word_i,
  input  logic               miso_i,
  output logic               sck_o,
  output logic               mosi_o,
  output logic               done_o,
  output logic [FRAME_W-1:0] rx_word_o
);

  localparam int unsigned HCNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int unsigned BCNT_W = $clog2(FRAME_W);

  logic               busy_q, sck_q, mosi_q, done_q;
  logic [HCNT_W-1:0]  hcnt_q;
  logic [BCNT_W-1:0]  bcnt_q;
  logic [FRAME_W-1:0] sh_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
      hcnt_q <= '0;
      bcnt_q <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_i && !busy_q) begin
        busy_q <= 1'b1;
        sck_q  <= 1'b0;
        hcnt_q <= HCNT_W'(HALF_DIV - 1);
        bcnt_q <= BCNT_W'(FRAME_W - 1);
        mosi_q <= tx_word_i[FRAME_W-1];
        sh_q   <= {tx_word_i[FRAME_W-2:0], 1'b0};
      end else if (busy_q) begin
        if (hcnt_q != '0) begin
          hcnt_q <= hcnt_q - 1'b1;
        end else begin
          hcnt_q <= HCNT_W'(HALF_DIV - 1);
          if (!sck_q) begin
            sck_q <= 1'b1;
            rx_q  <= {rx_q[FRAME_W-2:0], miso_i};
          end else begin
            sck_q <= 1'b0;
            if (bcnt_q == '0) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
              mosi_q <= 1'b0;
            end else begin
              bcnt_q <= bcnt_q - 1'b1;
              mosi_q <= sh_q[FRAME_W-1];
              sh_q   <= {sh_q[FRAME_W-2:0], 1'b0};
            end
          end
        end
      end
    end
  end

  assign sck_o     = sck_q;
  assign mosi_o    = mosi_q;
  assign done_o    = done_q;
  assign rx_word_o = rx_q;

  a_r9_go_only_when_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> !busy_q);
  a_r5_mosi_still_while_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_q |-> $stable(mosi_q));

endmodule

// File: rtl/spi_txn_seq.sv
module spi_txn_seq
  import spi_txn_pkg::*;
#(
  parameter int unsigned HALF_DIV = 5,
  parameter int unsigned CS_LEAD  = 10,
  parameter int unsigned CS_HOLD  = 5,
  parameter int unsigned WORD_GAP = 10,
  parameter int unsigned ECHO_IDX = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  txn_req_t           req_i,
  output logic               req_ready_o,
  output txn_req_t           req_q_o,
  input  logic [FRAME_W-1:0] hdr_i,
  output logic               go_o,
  output logic [FRAME_W-1:0] tx_word_o,
  input  logic               shift_done_i,
  input  logic [FRAME_W-1:0] rx_word_i,
  output logic               cs_n_o,
  output logic               done_o,
  output logic               err_o,
  output logic [FRAME_W-1:0] rdata_o
);

  localparam int unsigned LEAD_WAIT  = CS_LEAD - HALF_DIV - 1;
  localparam int unsigned GAP_WAIT   = WORD_GAP - HALF_DIV - 2;
  localparam int unsigned HOLD_WAIT  = CS_HOLD - 2;
  localparam int unsigned CNT_W      = $clog2(CS_LEAD + CS_HOLD + WORD_GAP + 1);
  localparam int unsigned RD_WORDS   = ECHO_IDX + 1;
  localparam int unsigned WIDX_W     = $clog2(RD_WORDS + 1);
  localparam bit          ECHO_CHECK = (ECHO_IDX >= 2);

  seq_state_e         state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [WIDX_W-1:0]  widx_q, last_idx;
  txn_req_t           req_q;
  logic [FRAME_W-1:0] echo_q, data_q, rdata_q;
  logic               cs_n_q, done_q, err_q;
  logic               wait_state;

  assign wait_state = (state_q == ST_LEAD) || (state_q == ST_GAP);
  assign go_o       = wait_state && (cnt_q == '0);
  assign last_idx   = req_q.wr ? WIDX_W'(1) : WIDX_W'(RD_WORDS - 1);
  assign tx_word_o  = (widx_q == '0) ? hdr_i : (req_q.wr ? req_q.wdata : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      widx_q  <= '0;
      req_q   <= '0;
      echo_q  <= '0;
      data_q  <= '0;
      rdata_q <= '0;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          req_q   <= req_i;
          cs_n_q  <= 1'b0;
          cnt_q   <= CNT_W'(LEAD_WAIT);
          widx_q  <= '0;
          state_q <= ST_LEAD;
        end
        ST_LEAD, ST_GAP: begin
          if (cnt_q == '0) state_q <= ST_SHIFT;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_SHIFT: if (shift_done_i) begin
          if (!req_q.wr && ECHO_CHECK && widx_q == WIDX_W'(1)) echo_q <= rx_word_i;
          if (!req_q.wr && widx_q == WIDX_W'(ECHO_IDX))        data_q <= rx_word_i;
          widx_q <= widx_q + 1'b1;
          if (widx_q == last_idx) begin
            state_q <= ST_HOLD;
            cnt_q   <= CNT_W'(HOLD_WAIT);
          end else begin
            state_q <= ST_GAP;
            cnt_q   <= CNT_W'(GAP_WAIT);
          end
        end
        ST_HOLD: begin
          if (cnt_q == '0) begin
            cs_n_q  <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
            if (!req_q.wr) begin
              rdata_q <= data_q;
              err_q   <= ECHO_CHECK && (echo_q != hdr_i);
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign req_q_o     = req_q;
  assign cs_n_o      = cs_n_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign rdata_o     = rdata_q;

  a_r2_busy_request_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && req_valid_i) |=> $stable(req_q));
  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_rdata_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rdata_o));
  a_r9_frame_end_in_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_done_i |-> (state_q == ST_SHIFT));
  a_r6_cs_low_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP) |-> !cs_n_o);

endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
  import spi_txn_pkg::*;
#(
  parameter int unsigned CLK_DIV  = 10,
  parameter int unsigned CS_LEAD  = 10,
  parameter int unsigned CS_HOLD  = 5,
  parameter int unsigned WORD_GAP = 10,
  parameter int unsigned ECHO_IDX = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic        req_write_i,
  input  logic [3:0]  req_mms_i,
  input  logic [15:0] req_addr_i,
  input  logic [31:0] req_wdata_i,
  output logic        done_o,
  output logic        err_o,
  output logic [31:0] rdata_o,
  output logic        spi_cs_no,
  output logic        spi_sck_o,
  output logic        spi_mosi_o,
  input  logic        spi_miso_i
);

  localparam int unsigned HALF_DIV = CLK_DIV / 2;

  txn_req_t           req_in, req_q;
  logic [FRAME_W-1:0] hdr, tx_word, rx_word;
  logic               go, shift_done;

  assign req_in = '{wr: req_write_i, mms: req_mms_i, addr: req_addr_i, wdata: req_wdata_i};

  spi_hdr_build i_hdr (
    .wr_i   (req_q.wr),
    .mms_i  (req_q.mms),
    .addr_i (req_q.addr),
    .hdr_o  (hdr)
  );

  spi_txn_seq #(
    .HALF_DIV (HALF_DIV),
    .CS_LEAD  (CS_LEAD),
    .CS_HOLD  (CS_HOLD),
    .WORD_GAP (WORD_GAP),
    .ECHO_IDX (ECHO_IDX)
  ) i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_i        (req_in),
    .req_ready_o  (req_ready_o),
    .req_q_o      (req_q),
    .hdr_i        (hdr),
    .go_o         (go),
    .tx_word_o    (tx_word),
    .shift_done_i (shift_done),
    .rx_word_i    (rx_word),
    .cs_n_o       (spi_cs_no),
    .done_o       (done_o),
    .err_o        (err_o),
    .rdata_o      (rdata_o)
  );

  spi_frame_shifter #(
    .FRAME_W  (FRAME_W),
    .HALF_DIV (HALF_DIV)
  ) i_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (go),
    .tx_word_i (tx_word),
    .miso_i    (spi_miso_i),
    .sck_o     (spi_sck_o),
    .mosi_o    (spi_mosi_o),
    .done_o    (shift_done),
    .rx_word_o (rx_word)
  );

  a_r5_sck_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sck_o);
  a_r1_ready_cs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> spi_cs_no);
  a_r10_done_cs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (spi_cs_no && req_ready_o));

endmodule

// File: tb/spi_slave_model.sv
module spi_slave_model #(
  parameter int ECHO    = 2,
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        cs_n,
  input  logic        sck,
  input  logic        mosi,
  output logic        miso,
  input  logic [31:0] reply_data,
  input  logic        corrupt
);

  logic [31:0] rx_words [4];
  logic [31:0] rsh = '0, txsh = '0;
  int nwords = 0, bits = 0, falls = 0, txk = 0;
  int lead = -1, gap_meas = -1, hold = -1;
  int per_bad = 0, glitches = 0, idle_bad = 0;
  int cyc = 0, t_csfall = 0, t_lastfall = 0, t_rise = 0;
  logic pcs = 1'b1, psck = 1'b0, pmosi = 1'b0;

  initial begin
    miso = 1'b0;
    for (int i = 0; i < 4; i++) rx_words[i] = '0;
  end

  function automatic logic [31:0] reply(input int k);
    if (k == 1 && ECHO >= 2) return rx_words[0] ^ (corrupt ? 32'h0000_0020 : 32'h0);
    if (k == ECHO)           return reply_data;
    return 32'hC3C3_0000 | 32'(k);
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (pcs && !cs_n) begin
      t_csfall = cyc; nwords = 0; bits = 0; falls = 0; txk = 0;
      txsh = reply(0); miso = txsh[31];
    end
    if (!pcs && cs_n) hold = cyc - t_lastfall;
    if (cs_n && sck) idle_bad++;
    if (!cs_n) begin
      if (!psck && sck) begin
        if (bits % 32 == 0) begin
          if (nwords == 0) lead = cyc - t_csfall;
          else             gap_meas = cyc - t_lastfall;
        end else if (cyc - t_rise != CLK_DIV) per_bad++;
        t_rise = cyc;
        rsh = {rsh[30:0], mosi};
        bits++;
        if (bits % 32 == 0) begin
          if (nwords < 4) rx_words[nwords] = rsh;
          nwords++;
        end
      end
      if (psck && !sck) begin
        t_lastfall = cyc;
        falls++;
        if (falls % 32 == 0) begin
          txk++;
          txsh = reply(txk);
        end else txsh = txsh << 1;
        miso = txsh[31];
      end
      if (psck && sck && mosi != pmosi) glitches++;
    end
    pcs = cs_n; psck = sck; pmosi = mosi;
  end

endmodule

// File: tb/test_spi_reg_master.sv
module test_spi_reg_master;

  localparam int CLK_DIV  = 4;
  localparam int CS_LEAD  = 4;
  localparam int CS_HOLD  = 3;
  localparam int WORD_GAP = 5;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        valid = 1'b0, wr = 1'b0;
  logic [3:0]  mms = '0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0, reply = '0;
  logic        corrupt = 1'b0;

  logic        rdy2, done2, err2, cs2, sck2, mosi2, miso2;
  logic        rdy1, done1, err1, cs1, sck1, mosi1, miso1;
  logic [31:0] rd2, rd1;

  int vectors = 0, miscompares = 0;
  int dcnt2 = 0, dcnt1 = 0;
  logic err2_s = 1'b0, err1_s = 1'b0;
  int cycles = 0;

  always #5 clk = ~clk;

  spi_reg_master #(.CLK_DIV(CLK_DIV), .CS_LEAD(CS_LEAD), .CS_HOLD(CS_HOLD),
                   .WORD_GAP(WORD_GAP), .ECHO_IDX(2)) i_spi_reg_master (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(rdy2),
    .req_write_i(wr), .req_mms_i(mms), .req_addr_i(addr), .req_wdata_i(wdata),
    .done_o(done2), .err_o(err2), .rdata_o(rd2),
    .spi_cs_no(cs2), .spi_sck_o(sck2), .spi_mosi_o(mosi2), .spi_miso_i(miso2));

  spi_reg_master #(.CLK_DIV(CLK_DIV), .CS_LEAD(CS_LEAD), .CS_HOLD(CS_HOLD),
                   .WORD_GAP(WORD_GAP), .ECHO_IDX(1)) i_spi_reg_master_e1 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(rdy1),
    .req_write_i(wr), .req_mms_i(mms), .req_addr_i(addr), .req_wdata_i(wdata),
    .done_o(done1), .err_o(err1), .rdata_o(rd1),
    .spi_cs_no(cs1), .spi_sck_o(sck1), .spi_mosi_o(mosi1), .spi_miso_i(miso1));

  spi_slave_model #(.ECHO(2), .CLK_DIV(CLK_DIV)) i_slv2 (
    .clk(clk), .cs_n(cs2), .sck(sck2), .mosi(mosi2), .miso(miso2),
    .reply_data(reply), .corrupt(corrupt));
  spi_slave_model #(.ECHO(1), .CLK_DIV(CLK_DIV)) i_slv1 (
    .clk(clk), .cs_n(cs1), .sck(sck1), .mosi(mosi1), .miso(miso1),
    .reply_data(reply), .corrupt(corrupt));

  always @(negedge clk) begin
    cycles++;
    if (done2) begin dcnt2++; err2_s = err2; end
    if (done1) begin dcnt1++; err1_s = err1; end
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, got %0d cycles exp < 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_hdr(input logic w, input logic [3:0] m, input logic [15:0] a);
    logic [31:0] h;
    int ones = 0;
    h = 32'(w) * 32'h2000_0000 + 32'(m) * 32'h0100_0000 + 32'(a) * 32'h100;
    for (int i = 1; i < 32; i++) ones += int'(h[i]);
    if (ones % 2 == 0) h[0] = 1'b1;
    return h;
  endfunction

  task automatic check_pins_idle(input string tag);
    chk({tag, " cs high"}, 32'(cs2 & cs1), 32'd1);
    chk({tag, " sck low"}, 32'(sck2 | sck1), 32'd0);
    chk({tag, " mosi low"}, 32'(mosi2 | mosi1), 32'd0);
    chk({tag, " ready"}, 32'(rdy2 & rdy1), 32'd1);
    chk({tag, " done low"}, 32'(done2 | done1), 32'd0);
  endtask

  task automatic run_txn(input logic w, input logic [3:0] m, input logic [15:0] a,
                         input logic [31:0] d, input logic [31:0] rep,
                         input logic bad_echo, input logic poke);
    logic [31:0] hdr, old2, old1;
    hdr = exp_hdr(w, m, a);
    old2 = rd2; old1 = rd1;
    @(negedge clk);
    wr = w; mms = m; addr = a; wdata = d; reply = rep; corrupt = bad_echo;
    dcnt2 = 0; dcnt1 = 0; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      wr = ~w; mms = ~m; addr = ~a; wdata = ~d; valid = 1'b1;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk("R2 ready low while busy", 32'(rdy2 | rdy1), 32'd0);
      end
      valid = 1'b0;
    end
    while (dcnt2 == 0 || dcnt1 == 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R3 R4 header e2", i_slv2.rx_words[0], hdr);
    chk("R3 R4 header e1", i_slv1.rx_words[0], hdr);
    chk("R10 one done e2", 32'(dcnt2), 32'd1);
    chk("R10 one done e1", 32'(dcnt1), 32'd1);
    if (w) begin
      chk("R6 frames e2", 32'(i_slv2.nwords), 32'd2);
      chk("R6 frames e1", 32'(i_slv1.nwords), 32'd2);
      chk("R6 data e2", i_slv2.rx_words[1], d);
      chk("R6 data e1", i_slv1.rx_words[1], d);
      chk("R6 rdata kept e2", rd2, old2);
      chk("R6 rdata kept e1", rd1, old1);
      chk("R8 no err on write", 32'(err2_s | err1_s), 32'd0);
    end else begin
      chk("R7 frames e2", 32'(i_slv2.nwords), 32'd3);
      chk("R7 frames e1", 32'(i_slv1.nwords), 32'd2);
      chk("R7 filler e2 w1", i_slv2.rx_words[1], 32'd0);
      chk("R7 filler e2 w2", i_slv2.rx_words[2], 32'd0);
      chk("R7 filler e1", i_slv1.rx_words[1], 32'd0);
      chk("R7 rdata e2", rd2, rep);
      chk("R7 rdata e1", rd1, rep);
      chk("R8 err e2", 32'(err2_s), 32'(bad_echo));
      chk("R8 err e1 off", 32'(err1_s), 32'd0);
    end
    chk("R9 lead", 32'(i_slv2.lead), 32'(CS_LEAD));
    chk("R9 gap", 32'(i_slv2.gap_meas), 32'(WORD_GAP));
    chk("R9 hold", 32'(i_slv2.hold), 32'(CS_HOLD));
    chk("R9 hold e1", 32'(i_slv1.hold), 32'(CS_HOLD));
    chk("R9 period", 32'(i_slv2.per_bad + i_slv1.per_bad), 32'd0);
    chk("R5 mosi steady in high", 32'(i_slv2.glitches + i_slv1.glitches), 32'd0);
    chk("R5 sck idle low", 32'(i_slv2.idle_bad + i_slv1.idle_bad), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_pins_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_pins_idle("R1 after reset");

    for (int m = 0; m < 16; m++) begin
      run_txn(1'b1, 4'(m), 16'(1) << m, 32'h0101_0101 * 32'(m + 1), 32'h0, 1'b0, 1'b0);
      run_txn(1'b0, 4'(m), 16'hFFFF ^ (16'(1) << m), 32'h0,
              32'hA000_0000 | (32'(m) << 8) | 32'(m * 3), 1'b0, 1'b0);
    end
    for (int b = 0; b < 16; b++)
      run_txn(1'b0, 4'(15 - b), 16'(1) << b, 32'h0, ~(32'(1) << (2 * b)), 1'b0, 1'b0);
    run_txn(1'b0, 4'hC, 16'hCA01, 32'h0, 32'h1234_5678, 1'b1, 1'b0);
    run_txn(1'b1, 4'h3, 16'h0003, 32'hDEAD_BEEF, 32'h0, 1'b1, 1'b0);
    run_txn(1'b0, 4'h1, 16'h000C, 32'h0, 32'h8765_4321, 1'b0, 1'b1);
    run_txn(1'b1, 4'h0, 16'h0000, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b1);

    // reset in the middle of a frame
    @(negedge clk);
    wr = 1'b0; mms = 4'h2; addr = 16'h0055; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_pins_idle("R1 mid-frame reset");
    chk("R1 rdata cleared", rd2 | rd1, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_txn(1'b0, 4'h5, 16'hBEEF, 32'h0, 32'h0F0F_F0F0, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule